// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

An eight-pin general-purpose I/O port reached through a plain memory-mapped register bus with byte-wide data. Each pin is set as an input or an output by a direction register. The block drives the pin output values and the per-pin output enables. Input pins are sampled through a two-flop synchronizer before any read path uses them.

Pin data is reached through a data window, where the address selects the pins that take part. Address bit n+2 enables pin n. A write therefore changes only the chosen pins, so software needs no read-modify-write. A read returns zero for every pin it did not select. One further address holds the direction register. Any other offset reads as zero, and writes to it are dropped.

The bus is a select/write/address/data interface with no handshake. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. A read is a cycle with `bus_sel` high and `bus_wr` low. Its result appears on `bus_rdata` after that edge and stays there until the next read.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the direction register and the output data register are 0: `pin_oe` = 0x00, `pin_out` = 0x00 and `bus_rdata` = 0x00, so every pin is an input.
- R2: A write at offset 0x400 loads the direction register. Bit n = 1 makes pin n an output and drives `pin_oe[n]` = 1. Bit n = 0 makes pin n an input. A read at 0x400 returns the register.
- R3: A write to the data window (offsets 0x000 to 0x3FF) changes output bit n only when address bit n+2 is 1. All other output bits keep their value.
- R4: A single pin n is written or read at the address with only bit n+2 set. Its value travels at data bit n.
- R5: A data-window write leaves the stored output bit of any pin that is an input at that moment unchanged. Switching that pin to an output later shows the old stored value, not the value that was written.
- R6: A data-window read returns 0 in every bit n whose address bit n+2 is 0.
- R7: In a data-window read with address bit n+2 set, bit n is the output register bit if pin n is an output. It is the synchronized input if pin n is an input.
- R8: Inputs pass through two flops. A change on `pin_in` driven before edge k first shows in a read issued at edge k+2.
- R9: Offsets at 0x404 and above, other than 0x400, read as 0x00. Writes to them change neither `pin_out` nor `pin_oe`.
- R10: `bus_rdata` is loaded at the edge of a read cycle and holds its value through cycles that are not reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read, when selected |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output data register |
| pin_oe | output | 8 | Per-pin output enable (direction) |

## Verification
Masked writes are tried with a full mask, a single-pin mask and a sparse mask. This separates a design that honours address bit n+2 from one that writes the whole byte or shifts the mask by a bit. The same writes are repeated with a mixed direction setting. That shows whether pins set as inputs are protected, and whether a later switch to output exposes the stored value or the written one. Reads combine the three masks with mixed directions and changing input patterns. They tell output read-back apart from input sampling and test the zero gating of unselected bits. A read issued on the first, second and third edge after an input change pins down the synchronizer depth. Accesses to unmapped offsets confirm that both the read data and the pins stay unchanged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DATA = 2'd1,
    RGN_DIR  = 2'd2
  } gpio_region_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  // R8: each stage takes the previous one's value one edge later
  a_r8_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage1_q == $past(async_in));
  a_r8_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage2_q == $past(stage1_q));
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_port_pkg::*;
#(
  parameter int                NPINS   = 8,
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] DIR_OFF = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output gpio_region_e      region,
  output logic [NPINS-1:0]  sel_mask,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q
);
  localparam int WIN_BITS = NPINS + 2;

  logic data_we;
  logic dir_we;

  always_comb begin
    if (addr[ADDR_W-1:WIN_BITS] == '0)
      region = RGN_DATA;
    else if (addr == DIR_OFF)
      region = RGN_DIR;
    else
      region = RGN_NONE;
  end

  assign sel_mask = addr[WIN_BITS-1:2];
  assign data_we  = sel && wr && (region == RGN_DATA);
  assign dir_we   = sel && wr && (region == RGN_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dir_q <= '0;
    else if (dir_we)
      dir_q <= wdata;
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_out_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        out_q[n] <= 1'b0;
      else if (data_we && sel_mask[n] && dir_q[n])
        out_q[n] <= wdata[n];
    end
  end

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == DIR_OFF) |=> dir_q == $past(wdata));
  // R3, R5: bits outside the mask or on input pins keep their value
  a_r3_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr[ADDR_W-1:WIN_BITS] == '0) |=>
      ((out_q ^ $past(out_q)) & ~($past(addr[WIN_BITS-1:2]) & $past(dir_q))) == '0);
  a_r5_input_pin_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr && addr[ADDR_W-1:WIN_BITS] == '0) |=> $stable(out_q));
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr[ADDR_W-1:WIN_BITS] != '0 && addr != DIR_OFF) |=>
      ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  gpio_region_e     region,
  input  logic [NPINS-1:0] sel_mask,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] rdata
);
  logic [NPINS-1:0] win_val;
  logic [NPINS-1:0] rd_next;

  for (genvar n = 0; n < NPINS; n++) begin : g_rd_bit
    assign win_val[n] = sel_mask[n] & (dir_q[n] ? out_q[n] : pin_sync[n]);
  end

  always_comb begin
    unique case (region)
      RGN_DATA: rd_next = win_val;
      RGN_DIR:  rd_next = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_next;
  end

  a_r6_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && region == RGN_DATA) |=> (rdata & ~$past(sel_mask)) == '0);
  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && region == RGN_NONE) |=> rdata == '0);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_port_pkg::*;
#(
  parameter int                NPINS   = 8,
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] DIR_OFF = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  gpio_region_e     region;
  logic [NPINS-1:0] sel_mask;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] pin_sync;

  gpio_in_sync #(.WIDTH(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_reg_bank #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .region   (region),
    .sel_mask (sel_mask),
    .dir_q    (dir_q),
    .out_q    (out_q)
  );

  gpio_read_mux #(.NPINS(NPINS)) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_sel && !bus_wr),
    .region   (region),
    .sel_mask (sel_mask),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R1: while reset is held everything reads as zero
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_state: assert (pin_oe == '0 && pin_out == '0 && bus_rdata == '0);
    end
  end
endmodule

// File: tb/test_gpio_masked_port.sv
`timescale 1ns/1ps
module test_gpio_masked_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_masked_port i_gpio_masked_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // behavioural reference model
  logic [7:0] m_dir, m_out, m_s1, m_s2, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_out = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
    end else begin
      int a;
      a = bus_addr;
      if (bus_sel && !bus_wr) begin
        if (a == 'h400) m_rd = m_dir;
        else if (a < 'h400) begin
          for (int n = 0; n < 8; n++)
            m_rd[n] = a[n+2] ? (m_dir[n] ? m_out[n] : m_s2[n]) : 1'b0;
        end else m_rd = 0;
      end
      if (bus_sel && bus_wr) begin
        if (a == 'h400) m_dir = bus_wdata;
        else if (a < 'h400) begin
          for (int n = 0; n < 8; n++)
            if (a[n+2] && m_dir[n]) m_out[n] = bus_wdata[n];
        end
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R2, R3, R7, R10)
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R3 model pin_out", pin_out, m_out);
      check("R2 model pin_oe", pin_oe, m_dir);
      check("R10 model rdata", bus_rdata, m_rd);
    end
  end

  task automatic bus_write(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk);
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #800000;
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check("R1 reset pin_oe", pin_oe, 8'h00);
    check("R1 reset pin_out", pin_out, 8'h00);
    check("R1 reset rdata", bus_rdata, 8'h00);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R5: write while all pins are inputs
    bus_write(12'h3FC, 8'hFF);
    check("R5 write to inputs ignored", pin_out, 8'h00);

    bus_write(12'h400, 8'h0F);
    check("R2 dir pin_oe", pin_oe, 8'h0F);
    bus_read(12'h400, rd);
    check("R2 dir readback", rd, 8'h0F);

    bus_write(12'h3FC, 8'hA5);
    check("R3 full mask write", pin_out, 8'h05);
    bus_write(12'h010, 8'hFF);              // bit 4 -> pin 2
    check("R4 single pin 2 set", pin_out, 8'h05);
    bus_write(12'h00C, 8'h02);              // pins 0,1 : pin0<-0 pin1<-1
    check("R3 sparse mask write", pin_out, 8'h06);
    bus_write(12'h020, 8'h08);              // only pin 3
    check("R4 single pin 3 set", pin_out, 8'h0E);

    pin_in = 8'hC3;
    repeat (4) @(negedge clk);
    bus_read(12'h3FC, rd);
    check("R7 mixed read", rd, 8'hCE);
    bus_read(12'h300, rd);                  // pins 6,7
    check("R6 partial mask read", rd, 8'hC0);
    bus_read(12'h008, rd);                  // pin 1 only
    check("R4 single pin read", rd, 8'h02);
    bus_read(12'h000, rd);
    check("R6 empty mask read", rd, 8'h00);

    // R8: read on first, second, third edge after input change
    bus_write(12'h400, 8'h00);
    @(negedge clk);
    pin_in = 8'h3C; bus_sel = 1; bus_wr = 0; bus_addr = 12'h3FC;
    @(posedge clk); #2 check("R8 first edge old", bus_rdata, 8'hC3);
    @(posedge clk); #2 check("R8 second edge old", bus_rdata, 8'hC3);
    @(posedge clk); #2 check("R8 third edge new", bus_rdata, 8'h3C);
    @(negedge clk); bus_sel = 0;
    repeat (2) @(negedge clk);
    check("R10 rdata held", bus_rdata, 8'h3C);

    // R5: pins 4..7 were written as inputs; switching shows old zeros
    bus_write(12'h400, 8'hFF);
    check("R5 old value after switch", pin_out, 8'h0E);
    bus_write(12'h3C0, 8'hF0);
    check("R5 rewrite after switch", pin_out, 8'hFE);

    // R9 unmapped
    bus_write(12'h404, 8'h00);
    bus_write(12'h800, 8'h00);
    bus_write(12'hFFC, 8'h00);
    check("R9 unmapped write pin_out", pin_out, 8'hFE);
    check("R9 unmapped write pin_oe", pin_oe, 8'hFF);
    bus_read(12'h404, rd);
    check("R9 unmapped read", rd, 8'h00);
    bus_read(12'hC00, rd);
    check("R9 unmapped read high", rd, 8'h00);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule